// File: doc/BRIEF.md
# Split Two-Section Decade Counter

A four-bit counter made of two sections that can run on their own or be joined. The low section divides by two and drives `q[0]`. The high section divides by five and drives `q[3:1]`. Each section has its own count input and steps once for every falling transition on that input. Both count inputs are sampled by the single system clock through a synchronizer. The falling transitions become one-cycle strobes, so the design has no ripple clocks.

An internal link selector joins the two sections without outside wiring. In decimal mode the high section steps whenever the low section wraps from one to zero, so `q` counts 0 to 9 in binary. In bi-quinary mode the low section steps whenever the high section wraps from four to zero, which makes `q[0]` the most significant digit.

Two gated controls override counting while they are applied. The clear forces every output to zero. The preset forces the value nine. Each control acts only when both of its inputs are high.

Top module: `decade_split_counter`

## Requirements
- R1: With `link_mode` = 2'b00 (independent), each falling transition of `edge_in_a` inverts `q[0]` and leaves `q[3:1]` unchanged.
- R2: With `link_mode` = 2'b00, each falling transition of `edge_in_b` steps `q[3:1]` through 0,1,2,3,4 and then back to 0, leaving `q[0]` unchanged; `q[3:1]` never exceeds 4.
- R3: A rising transition on either count input changes nothing, and the count is stable while no strobe and no control is active.
- R4: With `link_mode` = 2'b01 (decimal), falling transitions of `edge_in_a` make `q` count 0 to 9 and wrap to 0; `edge_in_b` is ignored.
- R5: With `link_mode` = 2'b10 (bi-quinary), falling transitions of `edge_in_b` make `{q[0],q[3:1]}` run 0..4 then 8..12 and wrap to 0; `edge_in_a` is ignored.
- R6: When `zero_req_a` and `zero_req_b` are both high and the preset is not applied, `q` becomes 0 at the next system clock edge; one of them alone has no effect.
- R7: When `nine_req_a` and `nine_req_b` are both high, `q` becomes 4'b1001 at the next system clock edge; one of them alone has no effect.
- R8: When both the preset and the clear are applied together, the preset wins and `q` is 4'b1001.
- R9: A falling transition whose strobe arrives while the clear or preset is applied is discarded; after release, the count stays at the forced value.
- R10: While `rst_n` is low, `q` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples everything |
| rst_n | input | 1 | Active-low system reset |
| edge_in_a | input | 1 | Count input of the divide-by-two section, acts on its falling transition |
| edge_in_b | input | 1 | Count input of the divide-by-five section, acts on its falling transition |
| zero_req_a | input | 1 | Clear gate input, first leg |
| zero_req_b | input | 1 | Clear gate input, second leg |
| nine_req_a | input | 1 | Preset-to-nine gate input, first leg |
| nine_req_b | input | 1 | Preset-to-nine gate input, second leg |
| link_mode | input | 2 | 00 independent, 01 decimal, 10 bi-quinary, 11 independent |
| q | output | 4 | Count outputs; q[0] from the low section, q[3:1] from the high section |

## Verification
The bench walks both linked modes through every state across the wrap points: 9 to 0 in decimal mode, and 4 to 8 and 12 to 0 in bi-quinary mode. A design with a wrong carry would skip or repeat a value at those points. It applies clears and presets in the middle of a sequence. It also drives each gate with only one leg high, which a design that ORed the legs would obey. It lands a count edge inside an active control, and a design that queued that edge would step right after release. Rising transitions and the unused input of each linked mode are toggled on their own. Any reaction to them shows up as a changed count.

// File: rtl/decade_split_pkg.sv
package decade_split_pkg;
   typedef enum logic [1:0] {
      LINK_NONE = 2'b00,
      LINK_BCD  = 2'b01,
      LINK_BIQ  = 2'b10,
      LINK_RSVD = 2'b11
   } link_mode_e;

   localparam int LO_MODULUS = 2;
   localparam int HI_MODULUS = 5;
   localparam int LO_WIDTH   = $clog2(LO_MODULUS);
   localparam int HI_WIDTH   = $clog2(HI_MODULUS);
   localparam int Q_WIDTH    = LO_WIDTH + HI_WIDTH;
endpackage

// File: rtl/fall_strobe.sv
module fall_strobe #(
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic strobe
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("fall_strobe: SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] chain;
   logic                   prev;

   generate
      genvar i;
      for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= IDLE_LEVEL;
               else        chain[i] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= IDLE_LEVEL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE_LEVEL;
      else        prev <= chain[LAST];
   end

   assign strobe = prev & ~chain[LAST];
endmodule

// File: rtl/mod_stage.sv
module mod_stage #(
   parameter int MODULUS    = 5,
   parameter int WIDTH      = $clog2(MODULUS),
   parameter int PRESET_VAL = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             force_zero,
   input  logic             force_preset,
   output logic [WIDTH-1:0] count,
   output logic             at_last
);
   generate
      if (MODULUS < 2) begin : g_bad_mod
         $error("mod_stage: MODULUS must be at least 2");
      end
      if (PRESET_VAL >= MODULUS || PRESET_VAL < 0) begin : g_bad_preset
         $error("mod_stage: PRESET_VAL out of range");
      end
      if ((1 << WIDTH) < MODULUS) begin : g_bad_width
         $error("mod_stage: WIDTH too small for MODULUS");
      end
   endgenerate

   localparam logic [WIDTH-1:0] LAST_VAL = WIDTH'(MODULUS - 1);
   localparam logic [WIDTH-1:0] SET_VAL  = WIDTH'(PRESET_VAL);

   logic [WIDTH-1:0] count_nxt;

   assign at_last = (count == LAST_VAL);

   always_comb begin
      count_nxt = count;
      if (force_preset)    count_nxt = SET_VAL;
      else if (force_zero) count_nxt = '0;
      else if (step)       count_nxt = at_last ? '0 : count + WIDTH'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count_nxt;
   end
endmodule

// File: rtl/link_router.sv
module link_router
   import decade_split_pkg::*;
(
   input  link_mode_e mode,
   input  logic       strobe_lo,
   input  logic       strobe_hi,
   input  logic       lo_last,
   input  logic       hi_last,
   input  logic       hold,
   output logic       step_lo,
   output logic       step_hi
);
   logic raw_lo;
   logic raw_hi;

   always_comb begin
      unique case (mode)
         LINK_BCD: begin
            raw_lo = strobe_lo;
            raw_hi = strobe_lo & lo_last;
         end
         LINK_BIQ: begin
            raw_lo = strobe_hi & hi_last;
            raw_hi = strobe_hi;
         end
         default: begin
            raw_lo = strobe_lo;
            raw_hi = strobe_hi;
         end
      endcase
   end

   assign step_lo = raw_lo & ~hold;
   assign step_hi = raw_hi & ~hold;
endmodule

// File: rtl/decade_split_counter.sv
module decade_split_counter
   import decade_split_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                edge_in_a,
   input  logic                edge_in_b,
   input  logic                zero_req_a,
   input  logic                zero_req_b,
   input  logic                nine_req_a,
   input  logic                nine_req_b,
   input  logic [1:0]          link_mode,
   output logic [Q_WIDTH-1:0]  q
);
   localparam int NUM_INPUTS = 2;

   logic [NUM_INPUTS-1:0] pins;
   logic [NUM_INPUTS-1:0] fall_hit;
   logic                  clear_on;
   logic                  preset_on;
   logic                  hold;
   logic                  step_lo;
   logic                  step_hi;
   logic                  lo_last;
   logic                  hi_last;
   logic [LO_WIDTH-1:0]   lo_count;
   logic [HI_WIDTH-1:0]   hi_count;
   link_mode_e            mode;

   assign pins      = {edge_in_b, edge_in_a};
   assign clear_on  = zero_req_a & zero_req_b;
   assign preset_on = nine_req_a & nine_req_b;
   assign hold      = clear_on | preset_on;
   assign mode      = link_mode_e'(link_mode);

   generate
      genvar k;
      for (k = 0; k < NUM_INPUTS; k++) begin : g_edge
         fall_strobe #(
            .SYNC_STAGES (SYNC_STAGES),
            .IDLE_LEVEL  (IDLE_LEVEL)
         ) u_fall (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pins[k]),
            .strobe (fall_hit[k])
         );
      end
   endgenerate

   link_router u_router (
      .mode      (mode),
      .strobe_lo (fall_hit[0]),
      .strobe_hi (fall_hit[1]),
      .lo_last   (lo_last),
      .hi_last   (hi_last),
      .hold      (hold),
      .step_lo   (step_lo),
      .step_hi   (step_hi)
   );

   mod_stage #(
      .MODULUS    (LO_MODULUS),
      .WIDTH      (LO_WIDTH),
      .PRESET_VAL (1)
   ) u_lo (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (step_lo),
      .force_zero   (clear_on),
      .force_preset (preset_on),
      .count        (lo_count),
      .at_last      (lo_last)
   );

   mod_stage #(
      .MODULUS    (HI_MODULUS),
      .WIDTH      (HI_WIDTH),
      .PRESET_VAL (4)
   ) u_hi (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (step_hi),
      .force_zero   (clear_on),
      .force_preset (preset_on),
      .count        (hi_count),
      .at_last      (hi_last)
   );

   assign q = {hi_count, lo_count};
endmodule

// File: rtl/decade_split_counter_chk.sv
module decade_split_counter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       zero_req_a,
   input logic       zero_req_b,
   input logic       nine_req_a,
   input logic       nine_req_b,
   input logic [1:0] link_mode,
   input logic [1:0] fall_hit,
   input logic [3:0] q
);
   logic clr_both;
   logic set_both;
   assign clr_both = zero_req_a & zero_req_b;
   assign set_both = nine_req_a & nine_req_b;

   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_both && !set_both) |=> (q == 4'd0));

   p_preset_nine_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_both |=> (q == 4'b1001));

   p_preset_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_both && clr_both) |=> (q == 4'b1001));

   p_hi_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q[3:1] <= 3'd4));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_hit == 2'b00 && !clr_both && !set_both) |=> $stable(q));

   p_bcd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (link_mode == 2'b01 && q <= 4'd9) |=> (q <= 4'd9));

   p_reset_zero_r10: assert property (@(posedge clk)
      !rst_n |-> (q == 4'd0));
endmodule

bind decade_split_counter decade_split_counter_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .zero_req_a (zero_req_a),
   .zero_req_b (zero_req_b),
   .nine_req_a (nine_req_a),
   .nine_req_b (nine_req_b),
   .link_mode  (link_mode),
   .fall_hit   (fall_hit),
   .q          (q)
);

// File: tb/decade_split_counter_tb.sv
module decade_split_counter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       edge_in_a = 1'b1;
   logic       edge_in_b = 1'b1;
   logic       zero_req_a = 1'b0;
   logic       zero_req_b = 1'b0;
   logic       nine_req_a = 1'b0;
   logic       nine_req_b = 1'b0;
   logic [1:0] link_mode = 2'b00;
   logic [3:0] q;

   int checks = 0;
   int errors = 0;
   int ma = 0;
   int mb = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   decade_split_counter u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_in_a  (edge_in_a),
      .edge_in_b  (edge_in_b),
      .zero_req_a (zero_req_a),
      .zero_req_b (zero_req_b),
      .nine_req_a (nine_req_a),
      .nine_req_b (nine_req_b),
      .link_mode  (link_mode),
      .q          (q)
   );

   function automatic logic [3:0] expect_q();
      return {mb[2:0], ma[0]};
   endfunction

   task automatic check(input string tag, input logic [3:0] exp);
      checks++;
      if (q !== exp) begin
         errors++;
         $display("FAIL %s: q actual %b expected %b", tag, q, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic bit held();
      return (zero_req_a & zero_req_b) | (nine_req_a & nine_req_b);
   endfunction

   // model of a falling edge on the low-section input
   function automatic void model_fall_a();
      if (held()) return;
      if (link_mode == 2'b01) begin
         if (ma == 1) mb = (mb + 1) % 5;
         ma ^= 1;
      end else if (link_mode != 2'b10) begin
         ma ^= 1;
      end
   endfunction

   function automatic void model_fall_b();
      if (held()) return;
      if (link_mode == 2'b10) begin
         if (mb == 4) ma ^= 1;
         mb = (mb + 1) % 5;
      end else if (link_mode != 2'b01) begin
         mb = (mb + 1) % 5;
      end
   endfunction

   task automatic pulse_a();
      edge_in_a = 1'b0;
      model_fall_a();
      wait_n(4);
      edge_in_a = 1'b1;
      wait_n(4);
   endtask

   task automatic pulse_b();
      edge_in_b = 1'b0;
      model_fall_b();
      wait_n(4);
      edge_in_b = 1'b1;
      wait_n(4);
   endtask

   task automatic apply_ctl(input logic [3:0] bits, input bit with_edge);
      {zero_req_a, zero_req_b, nine_req_a, nine_req_b} = bits;
      if (nine_req_a & nine_req_b) begin ma = 1; mb = 4; end
      else if (zero_req_a & zero_req_b) begin ma = 0; mb = 0; end
      wait_n(1);
      if (with_edge) pulse_a(); else wait_n(3);
      {zero_req_a, zero_req_b, nine_req_a, nine_req_b} = 4'b0000;
      wait_n(3);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      wait_n(3);
      check("R10 reset", 4'd0);
      rst_n = 1'b1;
      wait_n(3);
      check("R10 after release", 4'd0);

      // R1 independent low section
      link_mode = 2'b00;
      for (int i = 0; i < 3; i++) begin
         pulse_a();
         check("R1 low toggle", expect_q());
      end
      // R2 high section wrap
      for (int i = 0; i < 6; i++) begin
         pulse_b();
         check("R2 high step", expect_q());
      end
      // R3 rising only changes nothing
      edge_in_a = 1'b0; wait_n(4);
      model_fall_a();
      check("R3 fall acts", expect_q());
      edge_in_a = 1'b1; wait_n(6);
      check("R3 rise ignored", expect_q());

      // R4 decimal sweep
      apply_ctl(4'b1100, 1'b0);
      link_mode = 2'b01;
      for (int i = 0; i < 12; i++) begin
         pulse_a();
         check("R4 decimal", expect_q());
         if (expect_q() > 4'd9) begin
            errors++;
            $display("FAIL R4 model: actual %0d expected <=9", expect_q());
         end
      end
      pulse_b();
      check("R4 high input ignored", expect_q());

      // R5 bi-quinary sweep
      apply_ctl(4'b1100, 1'b0);
      link_mode = 2'b10;
      for (int i = 0; i < 12; i++) begin
         pulse_b();
         check("R5 biquinary", expect_q());
      end
      pulse_a();
      check("R5 low input ignored", expect_q());

      // R6/R7/R8 mid-sequence controls
      pulse_b();
      apply_ctl(4'b1000, 1'b0);
      check("R6 one leg ignored", expect_q());
      apply_ctl(4'b1100, 1'b0);
      check("R6 clear", 4'd0);
      apply_ctl(4'b0010, 1'b0);
      check("R7 one leg ignored", 4'd0);
      apply_ctl(4'b0011, 1'b0);
      check("R7 preset nine", 4'b1001);
      apply_ctl(4'b0000, 1'b0);
      apply_ctl(4'b1100, 1'b0);
      apply_ctl(4'b1111, 1'b0);
      check("R8 preset wins", 4'b1001);
      // R9 edge during control discarded
      link_mode = 2'b00;
      apply_ctl(4'b1100, 1'b1);
      check("R9 edge under clear", 4'd0);
      apply_ctl(4'b0011, 1'b1);
      check("R9 edge under preset", 4'b1001);

      // random mix
      for (int n = 0; n < 300; n++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op < 4)       pulse_a();
         else if (op < 8)  pulse_b();
         else if (op == 8) apply_ctl(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
         else              link_mode = 2'($urandom_range(0, 3));
         if (op != 9) check("R1 R2 R4 R5 R6 R7 R9 random", expect_q());
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule